// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Controller

This block lets four local interrupt sources share the active-low interrupt request line of an 8-bit CPU bus that uses vectored interrupts. Each source raises a request; the block keeps a pending flag and an in-service flag per channel. It also takes part in a priority chain of devices through an enable input and an enable output. Devices nearer the CPU sit higher in the chain and win over the ones further down.

When the CPU acknowledges an interrupt (M1 and IORQ low, RD high), the block inserts its own wait states. If its chain enable input is high, its most urgent eligible channel then drives a vector byte onto the data bus. That channel moves from pending to in-service. Service ends when the block sees the two-byte return-from-interrupt opcode on instruction fetches while its chain input is high. Each such return retires the most urgent channel in service, which gives properly nested service. A plain write strobe loads the vector base.

Top module: `vint_chain`

## Requirements
- R1: After reset no channel is pending or in service: `int_n` and `wait_n` are high, `data_oe` is low, and `ieo` follows `iei`.
- R2: A request seen on a clock edge with `m1_n` high sets that channel's pending flag. The following cycle `int_n` goes low if `iei` is high and no equal or more urgent channel is in service.
- R3: A request present only on clock edges where `m1_n` is low is ignored: no pending flag is set.
- R4: An acknowledge is `m1_n`=0, `iorq_n`=0, `rd_n`=1. During it, `wait_n` is low for exactly the first 2 clock cycles (WAIT_CYCLES) and then high, however long the acknowledge is held.
- R5: `data_oe` is high only inside an acknowledge that this block won, from its second cycle until IORQ or M1 returns high. During that time `data_o` holds the vector and stays stable across extra wait cycles. At all other times `data_oe` is low.
- R6: Channel 0 is the most urgent and channel 3 the least. When several channels are pending, the most urgent eligible one wins the acknowledge and moves from pending to in-service.
- R7: A pending channel is not eligible while it or a more urgent channel is in service (`int_n` stays high). A more urgent channel is eligible while only less urgent ones are in service.
- R8: While `iei` is low, `int_n` is high, `ieo` is low, an acknowledge makes no vector drive, pending flags are kept, and a return opcode clears nothing.
- R9: `ieo` is low when `iei` is low, when any channel is in service, or when any channel is pending and M1 is inactive or an acknowledge is under way. During a non-acknowledge M1 cycle, pending alone does not pull `ieo` low.
- R10: A fetch of byte 0xED followed by a fetch of 0x4D, with `iei` high at the end of the second fetch, clears the in-service flag of the most urgent channel in service. Any other byte between the two, or 0x4D alone, clears nothing. A fetch is `m1_n`=0, `rd_n`=0, `iorq_n`=1, and the byte is taken at its last cycle.
- R11: `base_we` loads `data_i` into the vector base. The vector is base bits 7..3, the channel number in bits 2..1, and bit 0 = 0. Base bits 2..0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NCH | Per-channel interrupt request, active high |
| m1_n | input | 1 | CPU M1 strobe, active low |
| iorq_n | input | 1 | CPU I/O request strobe, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| base_we | input | 1 | Load vector base from `data_i` |
| data_i | input | 8 | Data bus input (opcodes, base value) |
| data_o | output | 8 | Vector byte driven to the bus |
| data_oe | output | 1 | Output enable for `data_o`; bus is released when low |
| wait_n | output | 1 | Wait request to the CPU, active low |
| int_n | output | 1 | Interrupt request, active low |
| iei | input | 1 | Chain enable from the more urgent neighbour |
| ieo | output | 1 | Chain enable to the less urgent neighbour |

## Verification
Single requests on different channels show that the channel number and base reach the right vector bits. Simultaneous requests on channels 1 and 3 separate the internal ranking from arrival order. Nested sequences show whether a return retires the most urgent service first and whether a blocked channel resurfaces afterwards. These are a less urgent request during service, then a more urgent one. Request pulses inside M1, acknowledges and returns with `iei` low, and broken opcode pairs such as ED 00 4D show that each freeze and gating path is honoured rather than bypassed. Acknowledges held for extra cycles show that the wait count is fixed and the vector stays stable.

// File: rtl/vint_pkg.sv
package vint_pkg;

  localparam logic [7:0] OP_PREFIX = 8'hED;
  localparam logic [7:0] OP_RETURN = 8'h4D;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_FETCH,
    BUS_ACK,
    BUS_OTHER
  } bus_kind_t;

  // Vector: base above the channel field, channel in bits ch_w..1, bit 0 clear.
  function automatic logic [7:0] vector_byte(input logic [7:0] base,
                                             input int unsigned ch_w,
                                             input logic [2:0] ch);
    logic [7:0] low_mask;
    low_mask = 8'((16'd1 << (ch_w + 1)) - 16'd1);
    return (base & ~low_mask) | (8'(ch) << 1);
  endfunction

endpackage

// File: rtl/vint_cycle_decode.sv
module vint_cycle_decode
  import vint_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       m1_n,
  input  logic       iorq_n,
  input  logic       rd_n,
  input  logic [7:0] data_i,
  output logic       m1_act,
  output logic       ack,
  output logic       ack_start,
  output logic       wait_n,
  output logic       reti_seen
);
  localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 2);

  bus_kind_t        kind;
  logic             fetch, fetch_q, fetch_end;
  logic             ack_q, prefix_q;
  logic [7:0]       op_q;
  logic [CNT_W-1:0] wcnt_q;

  always_comb begin
    if (m1_n)                  kind = iorq_n ? BUS_IDLE : BUS_OTHER;
    else if (!iorq_n && rd_n)  kind = BUS_ACK;
    else if (iorq_n && !rd_n)  kind = BUS_FETCH;
    else                       kind = BUS_OTHER;
  end

  assign m1_act    = ~m1_n;
  assign ack       = (kind == BUS_ACK);
  assign fetch     = (kind == BUS_FETCH);
  assign ack_start = ack & ~ack_q;
  assign fetch_end = fetch_q & ~fetch;
  assign reti_seen = fetch_end & prefix_q & (op_q == OP_RETURN);
  assign wait_n    = ~(ack & (wcnt_q < CNT_W'(WAIT_CYCLES)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      fetch_q  <= 1'b0;
      op_q     <= 8'h00;
      prefix_q <= 1'b0;
      wcnt_q   <= '0;
    end else begin
      ack_q   <= ack;
      fetch_q <= fetch;
      if (fetch) op_q <= data_i;
      if (fetch_end) prefix_q <= (op_q == OP_PREFIX);
      if (!ack) wcnt_q <= '0;
      else if (wcnt_q < CNT_W'(WAIT_CYCLES)) wcnt_q <= wcnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/vint_prio.sv
module vint_prio #(
  parameter int unsigned NCH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         req_i,
  input  logic                   m1_act,
  input  logic                   ack,
  input  logic                   ack_start,
  input  logic                   reti_seen,
  input  logic                   iei,
  output logic [NCH-1:0]         pend_o,
  output logic [NCH-1:0]         isr_o,
  output logic                   int_req,
  output logic                   grant_fire,
  output logic [$clog2(NCH)-1:0] win_ch,
  output logic                   pop_fire,
  output logic                   ieo
);
  localparam int unsigned    CH_W  = $clog2(NCH);
  localparam logic [NCH-1:0] ONE_V = NCH'(1);

  // A channel is eligible when neither it nor any more urgent channel is in service.
  function automatic logic [NCH-1:0] eligible_of(input logic [NCH-1:0] p,
                                                 input logic [NCH-1:0] s);
    logic [NCH-1:0] e;
    logic           blk;
    blk = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      blk  = blk | s[i];
      e[i] = p[i] & ~blk;
    end
    return e;
  endfunction

  function automatic logic [NCH-1:0] lowest_onehot(input logic [NCH-1:0] v);
    return v & (~v + ONE_V);
  endfunction

  function automatic logic [CH_W-1:0] index_of(input logic [NCH-1:0] oh);
    logic [CH_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NCH; i++) if (oh[i]) idx = CH_W'(i);
    return idx;
  endfunction

  logic [NCH-1:0] pend_q, isr_q, elig, win_oh, pop_oh;

  assign elig       = eligible_of(pend_q, isr_q);
  assign int_req    = iei & (|elig);
  assign grant_fire = ack_start & iei & (|elig);
  assign win_oh     = lowest_onehot(elig);
  assign win_ch     = index_of(win_oh);
  assign pop_fire   = reti_seen & iei & (|isr_q);
  assign pop_oh     = lowest_onehot(isr_q);
  assign ieo        = iei & ~(|isr_q) & ~((|pend_q) & (~m1_act | ack));
  assign pend_o     = pend_q;
  assign isr_o      = isr_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic p_q, s_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_q <= 1'b0;
        s_q <= 1'b0;
      end else begin
        if (grant_fire && win_oh[g])  p_q <= 1'b0;
        else if (!m1_act && req_i[g]) p_q <= 1'b1;
        if (grant_fire && win_oh[g])    s_q <= 1'b1;
        else if (pop_fire && pop_oh[g]) s_q <= 1'b0;
      end
    end
    assign pend_q[g] = p_q;
    assign isr_q[g]  = s_q;
  end

endmodule

// File: rtl/vint_chain.sv
module vint_chain
  import vint_pkg::*;
#(
  parameter int unsigned NCH         = 4,
  parameter int unsigned WAIT_CYCLES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_i,
  input  logic           m1_n,
  input  logic           iorq_n,
  input  logic           rd_n,
  input  logic           base_we,
  input  logic [7:0]     data_i,
  output logic [7:0]     data_o,
  output logic           data_oe,
  output logic           wait_n,
  output logic           int_n,
  input  logic           iei,
  output logic           ieo
);
  localparam int unsigned CH_W = $clog2(NCH);

  logic            m1_act, ack, ack_start, reti_seen;
  logic [NCH-1:0]  pend_w, isr_w;
  logic            int_req, grant_fire, pop_fire;
  logic [CH_W-1:0] win_ch, grant_ch_q;
  logic            grant_vld_q;
  logic [7:0]      base_q;

  vint_cycle_decode #(.WAIT_CYCLES(WAIT_CYCLES)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .m1_n      (m1_n),
    .iorq_n    (iorq_n),
    .rd_n      (rd_n),
    .data_i    (data_i),
    .m1_act    (m1_act),
    .ack       (ack),
    .ack_start (ack_start),
    .wait_n    (wait_n),
    .reti_seen (reti_seen)
  );

  vint_prio #(.NCH(NCH)) u_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .m1_act     (m1_act),
    .ack        (ack),
    .ack_start  (ack_start),
    .reti_seen  (reti_seen),
    .iei        (iei),
    .pend_o     (pend_w),
    .isr_o      (isr_w),
    .int_req    (int_req),
    .grant_fire (grant_fire),
    .win_ch     (win_ch),
    .pop_fire   (pop_fire),
    .ieo        (ieo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q      <= 8'h00;
      grant_vld_q <= 1'b0;
      grant_ch_q  <= '0;
    end else begin
      if (base_we) base_q <= data_i;
      if (grant_fire) begin
        grant_vld_q <= 1'b1;
        grant_ch_q  <= win_ch;
      end else if (!ack) begin
        grant_vld_q <= 1'b0;
      end
    end
  end

  assign data_oe = ack & grant_vld_q;
  assign data_o  = data_oe ? vector_byte(base_q, CH_W, 3'(grant_ch_q)) : 8'h00;
  assign int_n   = ~int_req;

endmodule

// File: rtl/vint_chain_chk.sv
module vint_chain_chk #(
  parameter int unsigned NCH         = 4,
  parameter int unsigned WAIT_CYCLES = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           m1_n,
  input logic           iorq_n,
  input logic           rd_n,
  input logic           iei,
  input logic           ieo,
  input logic           int_n,
  input logic           wait_n,
  input logic           data_oe,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] isr,
  input logic           grant_fire,
  input logic           pop_fire
);
  logic [7:0] wait_run;

  always_ff @(posedge clk) begin
    if (!rst_n)      wait_run <= 8'd0;
    else if (!wait_n) wait_run <= wait_run + 8'd1;
    else             wait_run <= 8'd0;
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_run <= 8'(WAIT_CYCLES)); // R4

  AST_OE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!m1_n && !iorq_n && rd_n)); // R5

  AST_PEND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!m1_n) |-> ((pend & ~$past(pend)) == '0)); // R3

  AST_NO_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !iei |-> int_n); // R8

  AST_IEO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!iei || (|isr)) |-> !ieo); // R9

  AST_GRANT_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |=> ($countones(isr) == $countones($past(isr)) + 1)); // R6

  AST_RETURN_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> ($countones(isr) + 1 == $countones($past(isr)))); // R10

endmodule

bind vint_chain vint_chain_chk #(.NCH(NCH), .WAIT_CYCLES(WAIT_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .m1_n       (m1_n),
  .iorq_n     (iorq_n),
  .rd_n       (rd_n),
  .iei        (iei),
  .ieo        (ieo),
  .int_n      (int_n),
  .wait_n     (wait_n),
  .data_oe    (data_oe),
  .pend       (pend_w),
  .isr        (isr_w),
  .grant_fire (grant_fire),
  .pop_fire   (pop_fire)
);

// File: tb/vint_chain_bench.sv
module vint_chain_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_i = 4'b0;
  logic       m1_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1;
  logic       base_we = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] data_o;
  logic       data_oe, wait_n, int_n, ieo;
  logic       iei = 1'b1;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vint_chain u_vint_chain (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .m1_n(m1_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .base_we(base_we), .data_i(data_i), .data_o(data_o),
    .data_oe(data_oe), .wait_n(wait_n), .int_n(int_n), .iei(iei), .ieo(ieo)
  );

  // Expected vector computed from R11: base[7:3], channel in [2:1], bit 0 zero.
  function automatic logic [7:0] exp_vec(input logic [7:0] base, input int ch);
    return {base[7:3], 3'b000} + 8'(ch * 2);
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic raise(input logic [3:0] m);
    @(negedge clk); req_i = m;
    @(negedge clk); req_i = 4'b0;
    #2;
  endtask

  task automatic fetch_op(input logic [7:0] b);
    @(negedge clk); m1_n = 0; rd_n = 0; data_i = b;
    @(negedge clk);
    @(negedge clk); m1_n = 1; rd_n = 1; data_i = 8'h00;
    @(negedge clk); #2;
  endtask

  task automatic do_return();
    fetch_op(8'hED);
    fetch_op(8'h4D);
  endtask

  task automatic do_ack(input int extra, input logic exp_oe, input logic [7:0] vec,
                        input string tag);
    int lows;
    lows = 0;
    @(negedge clk); m1_n = 0;
    @(negedge clk);
    @(negedge clk); iorq_n = 0; rd_n = 1;
    #2;
    if (!wait_n) lows++;
    chk({tag, " R5 no drive in first ack cycle"}, data_oe, 0);
    for (int k = 0; k < 2 + extra; k++) begin
      @(negedge clk); #2;
      if (!wait_n) lows++;
      chk({tag, " R5 drive enable"}, data_oe, exp_oe);
      if (exp_oe) chk({tag, " R5 R11 vector"}, data_o, vec);
    end
    chk({tag, " R4 wait cycles"}, lows, 2);
    @(negedge clk); m1_n = 1; iorq_n = 1;
    #2;
    chk({tag, " R5 released after ack"}, data_oe, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    #2;
    chk("R1 int_n", int_n, 1);
    chk("R1 wait_n", wait_n, 1);
    chk("R1 data_oe", data_oe, 0);
    chk("R1 ieo follows iei", ieo, 1);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_base();
    @(negedge clk); base_we = 1; data_i = 8'hAF;
    @(negedge clk); base_we = 0; data_i = 8'h00;
    #2;
    chk("R11 base write leaves int_n high", int_n, 1);
  endtask

  task automatic t_single();
    raise(4'b0100);
    chk("R2 int_n after request", int_n, 0);
    chk("R9 ieo low with pending", ieo, 0);
    @(negedge clk); m1_n = 0; rd_n = 0;
    #2;
    chk("R9 ieo released by pending during M1", ieo, 1);
    @(negedge clk); m1_n = 1; rd_n = 1;
    @(negedge clk); #2;
    chk("R9 ieo low again after M1", ieo, 0);
    do_ack(0, 1, exp_vec(8'hAF, 2), "single ch2");
    chk("R6 int_n high after grant", int_n, 1);
    chk("R9 ieo low while in service", ieo, 0);
    do_return();
    chk("R10 ieo high after return", ieo, 1);
  endtask

  task automatic t_priority();
    raise(4'b1010);
    chk("R2 int_n with two requests", int_n, 0);
    do_ack(0, 1, exp_vec(8'hAF, 1), "prio ch1 over ch3");
    chk("R7 ch3 blocked by ch1 service", int_n, 1);
    do_return();
    chk("R10 R7 ch3 eligible after return", int_n, 0);
    do_ack(3, 1, exp_vec(8'hAF, 3), "ch3 with extra waits");
    do_return();
    chk("R10 ieo idle", ieo, 1);
  endtask

  task automatic t_nested();
    raise(4'b1000);
    do_ack(0, 1, exp_vec(8'hAF, 3), "nest ch3");
    raise(4'b0001);
    chk("R7 ch0 interrupts ch3 service", int_n, 0);
    do_ack(0, 1, exp_vec(8'hAF, 0), "nest ch0");
    do_return();
    chk("R10 first return keeps ch3 in service", ieo, 0);
    chk("R10 nothing pending", int_n, 1);
    do_return();
    chk("R10 second return clears ch3", ieo, 1);
  endtask

  task automatic t_freeze();
    @(negedge clk); m1_n = 0; rd_n = 0;
    @(negedge clk); req_i = 4'b0010;
    @(negedge clk); req_i = 4'b0000;
    @(negedge clk); m1_n = 1; rd_n = 1;
    @(negedge clk); #2;
    chk("R3 request during M1 ignored int_n", int_n, 1);
    chk("R3 request during M1 ignored ieo", ieo, 1);
  endtask

  task automatic t_gated();
    @(negedge clk); iei = 0;
    raise(4'b0001);
    chk("R8 int_n high with iei low", int_n, 1);
    chk("R8 ieo low with iei low", ieo, 0);
    do_ack(0, 0, 8'h00, "R8 gated ack");
    @(negedge clk); iei = 1;
    #2;
    chk("R8 pending kept", int_n, 0);
    do_ack(0, 1, exp_vec(8'hAF, 0), "after gate ch0");
    @(negedge clk); iei = 0;
    do_return();
    @(negedge clk); iei = 1;
    #2;
    chk("R8 return ignored with iei low", ieo, 0);
    do_return();
    chk("R10 return with iei high", ieo, 1);
  endtask

  task automatic t_broken_return();
    raise(4'b0010);
    do_ack(0, 1, exp_vec(8'hAF, 1), "broken ch1");
    fetch_op(8'hED);
    fetch_op(8'h00);
    fetch_op(8'h4D);
    chk("R10 ED 00 4D does not return", ieo, 0);
    do_return();
    chk("R10 ED 4D returns", ieo, 1);
  endtask

  initial begin
    t_reset();
    t_base();
    t_single();
    t_priority();
    t_nested();
    t_freeze();
    t_gated();
    t_broken_return();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule